// File: doc/BRIEF.md
# Correlating Two-Level Branch Direction Predictor

This block predicts whether a conditional branch will be taken. A short global history register holds the directions of the most recently resolved branches, whichever branches those were. That history picks one of several pattern tables. Low-order bits of the branch address then pick one saturating counter inside the chosen table. The most significant bit of that counter is the prediction. Because the table is chosen by the behaviour of neighbouring branches, a branch whose direction depends on an earlier branch can be predicted from that earlier outcome.

The fetch side presents an address on the lookup port and reads back a combinational direction. When a branch resolves, the execute side presents its address and actual direction on the training port for one cycle. The counter selected by the current history and that address moves one step toward the outcome. In the same clock edge the history shifts left and takes in the new direction. Different branches that share index bits share a counter. Storage is `2^HIST_BITS * 2^IDX_BITS * CTR_BITS` bits.

Top module: `corr_branch_predictor`

## Requirements
- R1: After reset the history register holds all zeros and every counter holds the weakly-not-taken value 01, so every address predicts not-taken.
- R2: `pred_taken` equals the most significant bit of the counter in the table chosen by the current history, at the entry chosen by the index bits of `pred_addr`; with no training pulse and a steady address it does not change.
- R3: A training pulse with `upd_taken` = 1 raises the selected counter by one, and the counter stays at 3 once it reaches 3 (four taken pulses from 01 leave it predicting taken).
- R4: A training pulse with `upd_taken` = 0 lowers the selected counter by one, and the counter stays at 0 once it reaches 0.
- R5: On each training pulse, after the counter step, the history shifts one place toward its most significant bit and `upd_taken` enters bit 0. The oldest direction drops out after three further pulses.
- R6: While `upd_valid` is 0, `upd_addr` and `upd_taken` change neither the counters nor the history.
- R7: The entry index is `addr[IDX_BITS+ALIGN_BITS-1:ALIGN_BITS]` (bits 5:2 by default). Addresses that differ only outside those bits share one counter.
- R8: Training under one history value changes only the table that history selects. The same address under another history still reads its own counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| pred_addr | input | ADDR_W | Address of the branch being looked up |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| upd_valid | input | 1 | One-cycle training pulse for a resolved branch |
| upd_addr | input | ADDR_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved direction, 1 = taken |

## Verification
The assertions check the history register on every clock. It must be clear right after reset leaves. Each training pulse must shift in exactly the resolved direction. Without a pulse the history must hold, and with a fixed lookup address the prediction must stay steady. Counter stepping, saturation at both ends, index aliasing and table separation leave no single-cycle signature at the ports. The bench shows them with hand-worked training sequences and reads each result back through later lookups.

// File: rtl/cbp_pkg.sv
package cbp_pkg;

    // Largest value an unsigned counter of the given width can hold.
    function automatic int unsigned ctr_ceiling(input int unsigned bits);
        return (1 << bits) - 1;
    endfunction

    // Value just below the taken threshold (01 for two-bit counters).
    function automatic int unsigned ctr_weak_nt(input int unsigned bits);
        return (1 << (bits - 1)) - 1;
    endfunction

endpackage

// File: rtl/cbp_history.sv
module cbp_history #(
    parameter int HIST_BITS = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 shift_en,
    input  logic                 dir_in,
    output logic [HIST_BITS-1:0] hist_q
);

    generate
        if (HIST_BITS == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)        hist_q <= 1'b0;
                else if (shift_en) hist_q <= dir_in;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)        hist_q <= '0;
                else if (shift_en) hist_q <= {hist_q[HIST_BITS-2:0], dir_in};
            end
        end
    endgenerate

endmodule

// File: rtl/cbp_counter_bank.sv
module cbp_counter_bank
    import cbp_pkg::*;
#(
    parameter int HIST_BITS = 3,
    parameter int IDX_BITS  = 4,
    parameter int CTR_BITS  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [HIST_BITS-1:0] rd_tbl,
    input  logic [IDX_BITS-1:0]  rd_idx,
    output logic [CTR_BITS-1:0]  rd_ctr,
    input  logic                 wr_en,
    input  logic [HIST_BITS-1:0] wr_tbl,
    input  logic [IDX_BITS-1:0]  wr_idx,
    input  logic                 wr_up
);

    localparam int TABLES = 1 << HIST_BITS;
    localparam int DEPTH  = 1 << IDX_BITS;
    localparam logic [CTR_BITS-1:0] CMAX = CTR_BITS'(ctr_ceiling(CTR_BITS));
    localparam logic [CTR_BITS-1:0] CINIT = CTR_BITS'(ctr_weak_nt(CTR_BITS));

    logic [CTR_BITS-1:0] cnt_q [TABLES][DEPTH];
    logic [CTR_BITS-1:0] wr_old;
    logic [CTR_BITS-1:0] wr_next;

    assign rd_ctr = cnt_q[rd_tbl][rd_idx];
    assign wr_old = cnt_q[wr_tbl][wr_idx];

    // Saturating one-step move toward the resolved direction.
    always_comb begin
        if (wr_up) wr_next = (wr_old == CMAX) ? wr_old : wr_old + 1'b1;
        else       wr_next = (wr_old == '0)   ? wr_old : wr_old - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int t = 0; t < TABLES; t++)
                for (int e = 0; e < DEPTH; e++)
                    cnt_q[t][e] <= CINIT;
        end else if (wr_en) begin
            cnt_q[wr_tbl][wr_idx] <= wr_next;
        end
    end

endmodule

// File: rtl/corr_branch_predictor.sv
module corr_branch_predictor #(
    parameter int ADDR_W     = 32,
    parameter int HIST_BITS  = 3,
    parameter int IDX_BITS   = 4,
    parameter int CTR_BITS   = 2,
    parameter int ALIGN_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] pred_addr,
    output logic              pred_taken,
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_addr,
    input  logic              upd_taken
);

    logic [HIST_BITS-1:0] hist_q;
    logic [IDX_BITS-1:0]  pred_idx;
    logic [IDX_BITS-1:0]  upd_idx;
    logic [CTR_BITS-1:0]  pred_ctr;

    assign pred_idx = pred_addr[ALIGN_BITS +: IDX_BITS];
    assign upd_idx  = upd_addr[ALIGN_BITS +: IDX_BITS];

    cbp_history #(
        .HIST_BITS(HIST_BITS)
    ) u_hist (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_en(upd_valid),
        .dir_in  (upd_taken),
        .hist_q  (hist_q)
    );

    cbp_counter_bank #(
        .HIST_BITS(HIST_BITS),
        .IDX_BITS (IDX_BITS),
        .CTR_BITS (CTR_BITS)
    ) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_tbl(hist_q),
        .rd_idx(pred_idx),
        .rd_ctr(pred_ctr),
        .wr_en (upd_valid),
        .wr_tbl(hist_q),
        .wr_idx(upd_idx),
        .wr_up (upd_taken)
    );

    assign pred_taken = pred_ctr[CTR_BITS-1];

endmodule

// File: rtl/cbp_checker.sv
module cbp_checker #(
    parameter int ADDR_W    = 32,
    parameter int HIST_BITS = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 upd_valid,
    input logic                 upd_taken,
    input logic [ADDR_W-1:0]    pred_addr,
    input logic                 pred_taken,
    input logic [HIST_BITS-1:0] hist
);

    a_r1_hist_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> hist == '0);

    a_r5_hist_shift: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> hist == HIST_BITS'({$past(hist), $past(upd_taken)}));

    a_r6_hist_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> $stable(hist));

    a_r2_pred_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(upd_valid) && $stable(pred_addr)) |-> $stable(pred_taken));

endmodule

bind corr_branch_predictor cbp_checker #(
    .ADDR_W   (ADDR_W),
    .HIST_BITS(HIST_BITS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_valid (upd_valid),
    .upd_taken (upd_taken),
    .pred_addr (pred_addr),
    .pred_taken(pred_taken),
    .hist      (hist_q)
);

// File: tb/corr_branch_predictor_tb.sv
module corr_branch_predictor_tb;

    localparam int NVEC = 12;
    // Each vector: {index[3:0], trained direction, expected prediction before training}
    localparam logic [5:0] VEC [NVEC] = '{
        {4'd4, 1'b1, 1'b0}, {4'd4, 1'b1, 1'b0}, {4'd4, 1'b1, 1'b0}, {4'd4, 1'b1, 1'b0},
        {4'd4, 1'b1, 1'b1}, {4'd4, 1'b0, 1'b1}, {4'd4, 1'b0, 1'b0}, {4'd4, 1'b0, 1'b0},
        {4'd4, 1'b0, 1'b1}, {4'd4, 1'b0, 1'b0}, {4'd4, 1'b0, 1'b0}, {4'd4, 1'b1, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pred_addr = '0;
    logic        pred_taken;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_addr = '0;
    logic        upd_taken = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    corr_branch_predictor u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pred_addr (pred_addr),
        .pred_taken(pred_taken),
        .upd_valid (upd_valid),
        .upd_addr  (upd_addr),
        .upd_taken (upd_taken)
    );

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic train(input logic [31:0] a, input logic t);
        upd_addr  = a;
        upd_taken = t;
        upd_valid = 1'b1;
        @(posedge clk);
        #1 upd_valid = 1'b0;
    endtask

    task automatic look(input string req, input logic [31:0] a, input logic exp);
        pred_addr = a;
        #1;
        n_tests++;
        if (pred_taken !== exp) begin
            n_fail++;
            $display("FAIL %s addr=%h actual=%b expected=%b", req, a, pred_taken, exp);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        do_reset();
        // R1: reset state, several addresses predict not-taken
        look("R1", 32'h0000_0000, 1'b0);
        look("R1", 32'h0000_0010, 1'b0);
        look("R1", 32'hFFFF_FFFC, 1'b0);

        // R2 R3 R4 R5 R8: one address under a moving history.
        // Step 6 reads table 6 while table 7 holds 2 (R8); step 10 checks the floor (R4).
        for (int i = 0; i < NVEC; i++) begin
            look($sformatf("R2/R5 step %0d", i), {26'd0, VEC[i][5:2], 2'b00}, VEC[i][0]);
            train({26'd0, VEC[i][5:2], 2'b00}, VEC[i][1]);
        end

        // R3: four taken pulses at history 7 lift 01 to saturated 11 (wrap would give 01)
        do_reset();
        repeat (3) train(32'h14, 1'b1);
        look("R8", 32'h14, 1'b0);
        repeat (4) train(32'h14, 1'b1);
        look("R3", 32'h14, 1'b1);

        // R6: inactive training inputs leave history and counters alone
        do_reset();
        upd_addr  = 32'h18;
        upd_taken = 1'b1;
        repeat (5) @(posedge clk);
        #1;
        look("R6", 32'h18, 1'b0);
        train(32'h18, 1'b1);
        repeat (3) train(32'h20, 1'b0);
        look("R6", 32'h18, 1'b1);

        // R7: aliasing by index bits 5:2 only
        do_reset();
        train(32'h10, 1'b1);
        repeat (3) train(32'h20, 1'b0);
        look("R7", 32'h50, 1'b1);
        look("R7", 32'h13, 1'b1);
        look("R7", 32'h14, 1'b0);
        // R8: same address, other history reads its own table
        train(32'h24, 1'b1);
        look("R8", 32'h10, 1'b0);

        summary();
        $finish;
    end

endmodule